// File: doc/BRIEF.md
# Selectable-Source Timer With Prescaler

This block is the 8-bit event timer of a small microcontroller. Each core clock cycle it can take one count tick from one of two sources. The first is the internal instruction-cycle enable. The second is an external pin, which is brought into the core clock domain and counted on the edge that software selects. A programmable divider may sit between the selected source and the counter, or the ticks may go straight to the counter. Software can load the count at any time and read it back. A sticky flag reports every wrap from 0xFF to 0x00.

The external path is built around a two-state edge tracker. The state `PIN_LOW` means the last synchronised pin value was 0, and `PIN_HIGH` means it was 1. The tracker has four transitions:
- `PIN_LOW` to `PIN_HIGH` on a synchronised 1. This gives a rising event.
- `PIN_HIGH` to `PIN_LOW` on a synchronised 0. This gives a falling event.
- `PIN_LOW` stays in `PIN_LOW` and `PIN_HIGH` stays in `PIN_HIGH` when the pin does not change.

The edge-select input decides which of the two events becomes a one-cycle count pulse. The divider is a free-running 8-bit counter. When the prescaler is assigned, it emits one tick for every 2^(ratio+1) source ticks. Any load of the count register while the prescaler is assigned clears the divider.

Top module: `tick_timer`

## Requirements
- R1: After reset, `rd_data` is 0x00 and `ovf_flag` is 0.
- R2: When `wr_en` is 1 at a clock edge, `rd_data` shows `wr_data` from the next cycle on.
- R3: With `src_ext`=0 and `pre_bypass`=1, the count rises by one at each edge where `cyc_en` is 1 and `wr_en` is 0.
- R4: With `src_ext`=1 and `edge_fall`=0, each 0-to-1 change of `ext_pin` adds one to the count. The pin passes through a two-flop synchroniser, so the count changes on the third clock edge after the pin changes. The pin must stay stable for at least two cycles for the change to count.
- R5: With `src_ext`=1 and `edge_fall`=1, each 1-to-0 change of `ext_pin` adds one to the count, and rising changes add nothing.
- R6: With `pre_bypass`=0, the count advances once per 2^(`pre_ratio`+1) source ticks, giving ratios from 1:2 (`pre_ratio`=0) to 1:256 (`pre_ratio`=7).
- R7: With `pre_bypass`=0, a write to the count clears the divider. After a write, a full 2^(`pre_ratio`+1) source ticks are needed for the next increment.
- R8: An increment from 0xFF to 0x00 sets `ovf_flag`, and the flag stays set until `ovf_clr` is 1 at an edge. If a wrap and `ovf_clr` occur at the same edge, the flag is set.
- R9: If a write and a count tick occur at the same edge, the written value is loaded and the tick is lost, so it cannot raise `ovf_flag`.
- R10: Only the selected source counts. `cyc_en` has no effect while `src_ext`=1, and `ext_pin` has no effect while `src_ext`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | Instruction-cycle tick (internal source) |
| ext_pin | input | 1 | External clock pin, asynchronous |
| src_ext | input | 1 | 1 selects the external pin, 0 selects the internal tick |
| edge_fall | input | 1 | 1 counts falling pin edges, 0 counts rising edges |
| pre_bypass | input | 1 | 0 routes ticks through the divider, 1 bypasses it |
| pre_ratio | input | 3 | Divider setting; division is 2^(value+1) |
| wr_en | input | 1 | Load strobe for the count register |
| wr_data | input | 8 | Value to load |
| rd_data | output | 8 | Current count |
| ovf_clr | input | 1 | Clears the wrap flag |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
Two pairs of events can land on the same edge. The first is a software load together with a count tick. The bench provokes it by asserting `wr_en` while `cyc_en` is high, including a load of 0xFF. The result is judged correct when the loaded value appears unchanged and `ovf_flag` stays low. The second pair is a wrap from 0xFF together with `ovf_clr`. The bench raises both in the same cycle and expects the flag to end set. The divider ratios are swept completely, and expected counts are computed as the number of ticks shifted right by ratio+1.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W   = 8;
    localparam int RATIO_W = 3;
    localparam int PRE_W   = 1 << RATIO_W;
    localparam int SYNC_N  = 2;

    typedef enum logic [0:0] {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync
    import tmr_pkg::*;
#(
    parameter int STAGES = SYNC_N
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              pin_s;
    pin_state_t        state_q, state_d;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= pin;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign pin_s = sync_q[STAGES-1];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_LOW:  if (pin_s)  state_d = PIN_HIGH;
            PIN_HIGH: if (!pin_s) state_d = PIN_LOW;
            default:  state_d = PIN_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        edge_pulse = 1'b0;
        unique case (state_q)
            PIN_LOW:  edge_pulse = pin_s && !fall_sel;
            PIN_HIGH: edge_pulse = !pin_s && fall_sel;
            default:  edge_pulse = 1'b0;
        endcase
    end

    // R4 / R5: an edge event is a single-cycle pulse
    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> !edge_pulse);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int RW = RATIO_W,
    localparam int PW = 1 << RW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_in,
    input  logic          bypass,
    input  logic [RW-1:0] ratio,
    input  logic          clear,
    output logic          tick_out
);
    logic [PW-1:0] div_q;
    logic [PW-1:0] mask;
    logic          assigned;

    assign assigned = !bypass;

    always_comb begin
        for (int i = 0; i < PW; i++) mask[i] = (i <= int'(ratio));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     div_q <= '0;
        else if (assigned && clear)     div_q <= '0;
        else if (assigned && tick_in)   div_q <= div_q + 1'b1;
    end

    always_comb begin
        if (bypass) tick_out = tick_in;
        else        tick_out = tick_in && ((div_q & mask) == mask);
    end

    // R7: a load while assigned empties the divider
    assert_clear_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (assigned && clear) |=> (div_q == '0));
    // R6: divider holds while no source tick arrives
    assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && !clear) |=> $stable(div_q));
endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         flag_clr,
    output logic [W-1:0] value,
    output logic         flag
);
    localparam logic [W-1:0] TOP = '1;
    logic wrap;

    assign wrap = inc && !load && (value == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= load_val;
        else if (inc)  value <= value + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (value == $past(load_val)));
    assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && value == TOP) |=> (flag && value == '0));
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_en,
    input  logic               ext_pin,
    input  logic               src_ext,
    input  logic               edge_fall,
    input  logic               pre_bypass,
    input  logic [RATIO_W-1:0] pre_ratio,
    input  logic               wr_en,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   rd_data,
    input  logic               ovf_clr,
    output logic               ovf_flag
);
    logic ext_tick;
    logic src_tick;
    logic cnt_tick;

    tmr_edge_sync #(.STAGES(SYNC_N)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (ext_pin),
        .fall_sel   (edge_fall),
        .edge_pulse (ext_tick)
    );

    assign src_tick = src_ext ? ext_tick : cyc_en;

    tmr_prescale #(.RW(RATIO_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (src_tick),
        .bypass   (pre_bypass),
        .ratio    (pre_ratio),
        .clear    (wr_en),
        .tick_out (cnt_tick)
    );

    tmr_count #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (cnt_tick),
        .load     (wr_en),
        .load_val (wr_data),
        .flag_clr (ovf_clr),
        .value    (rd_data),
        .flag     (ovf_flag)
    );

    assert_bypass_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_bypass && !src_ext && cyc_en && !wr_en) |=> (rd_data == $past(rd_data) + 1'b1));
    assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data)));
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ext && !cyc_en && !wr_en) |=> $stable(rd_data));
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0, ext_pin = 1'b0, src_ext = 1'b0, edge_fall = 1'b0;
    logic       pre_bypass = 1'b1;
    logic [2:0] pre_ratio = 3'd0;
    logic       wr_en = 1'b0, ovf_clr = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .src_ext(src_ext), .edge_fall(edge_fall), .pre_bypass(pre_bypass),
        .pre_ratio(pre_ratio), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        cyc_en = 1'b1;
        repeat (n) step();
        cyc_en = 1'b0;
    endtask

    task automatic toggle_pin(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b1; repeat (4) step();
            ext_pin = 1'b0; repeat (4) step();
        end
        repeat (4) step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int exp;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 count", rd_data, 0);
        chk("R1 flag", ovf_flag, 0);

        // R2: load sweep
        for (int v = 0; v < 256; v += 17) begin
            load(8'(v));
            chk("R2 load", rd_data, v);
        end

        // R3: internal source, bypassed divider, gapped ticks
        load(8'd0);
        exp = 0;
        for (int i = 0; i < 40; i++) begin
            cyc_en = (i % 3 != 0);
            if (i % 3 != 0) exp++;
            step();
        end
        cyc_en = 1'b0;
        chk("R3 gapped count", rd_data, exp);

        // R6 / R7: every ratio
        pre_bypass = 1'b0;
        for (int r = 0; r < 8; r++) begin
            int per;
            int t;
            per = 1 << (r + 1);
            t = 3 * per + (per >> 1);
            pre_ratio = 3'(r);
            load(8'd0);
            ticks(t);
            chk("R6 divided count", rd_data, t >> (r + 1));
            load(8'd0);
            ticks(per >> 1);
            load(8'd0);
            ticks(per - 1);
            chk("R7 cleared divider short", rd_data, 0);
            ticks(1);
            chk("R7 cleared divider full", rd_data, 1);
        end
        pre_bypass = 1'b1;

        // R4: rising pin edges; cyc_en busy but ignored (R10)
        src_ext = 1'b1; edge_fall = 1'b0;
        load(8'd0);
        cyc_en = 1'b1;
        toggle_pin(10);
        cyc_en = 1'b0;
        chk("R4 rising edges", rd_data, 10);

        // R4 latency: third edge after pin change
        load(8'd0);
        ext_pin = 1'b1;
        step(); step();
        chk("R4 not yet", rd_data, 0);
        step();
        chk("R4 latency", rd_data, 1);
        ext_pin = 1'b0; repeat (4) step();

        // R5: falling edges
        edge_fall = 1'b1;
        load(8'd0);
        toggle_pin(7);
        chk("R5 falling edges", rd_data, 7);
        ext_pin = 1'b1; repeat (5) step();
        chk("R5 rise ignored", rd_data, 7);
        ext_pin = 1'b0; repeat (5) step();
        edge_fall = 1'b0;

        // R10: internal source, pin ignored
        src_ext = 1'b0;
        load(8'd33);
        toggle_pin(5);
        chk("R10 pin ignored", rd_data, 33);

        // R8: wrap and sticky flag
        load(8'hFE);
        ticks(1);
        chk("R8 no flag at FF", ovf_flag, 0);
        ticks(1);
        chk("R8 wrap value", rd_data, 0);
        chk("R8 flag set", ovf_flag, 1);
        ticks(3);
        chk("R8 flag sticky", ovf_flag, 1);
        ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
        chk("R8 flag cleared", ovf_flag, 0);
        load(8'hFF);
        cyc_en = 1'b1; ovf_clr = 1'b1; step(); cyc_en = 1'b0; ovf_clr = 1'b0;
        chk("R8 set beats clear", ovf_flag, 1);
        ovf_clr = 1'b1; step(); ovf_clr = 1'b0;

        // R9: write and tick together
        cyc_en = 1'b1;
        wr_en = 1'b1; wr_data = 8'd5; step(); wr_en = 1'b0; cyc_en = 1'b0;
        chk("R9 write wins", rd_data, 5);
        cyc_en = 1'b1;
        wr_en = 1'b1; wr_data = 8'hFF; step(); wr_en = 1'b0; cyc_en = 1'b0;
        step();
        chk("R9 value kept", rd_data, 255);
        chk("R9 no flag", ovf_flag, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule